// File: doc/BRIEF.md
# Strobed Input Capture Port with Interrupts

This block is a 24-bit digital input port behind a small register interface. Every input line, and a separate strobe line, goes through a two-flop synchroniser. Software can read the live synchronised input word at any moment. It can also read a snapshot that the port took when the strobe rose. A sticky strobe flag tells software whether that snapshot holds valid data. While the flag is set, the snapshot is frozen against later strobes until software issues a clear.

The eight lowest inputs are interrupt sources. Each has an enable bit and a source-select bit. With the select bit low, a rising edge on the input raises the interrupt directly. With it high, the interrupt is raised only when an accepted strobe captures a 1 on that input. Pending interrupts stay set until a clear command. The request output is high while any enabled interrupt is pending. It is paired with a vector equal to an externally supplied base plus the index of the lowest-numbered enabled pending input.

Top module: `strobe_capture_irq`

## Requirements
- R1: A read at address 0 returns the synchronised input word in bits 23:0. A change on the input pins appears there after exactly two rising clock edges.
- R2: A rising edge of the synchronised strobe, while the strobe flag is clear, captures the synchronised input word and sets status bit 0. Both results appear three clock edges after the strobe pin rises. A read at address 1 returns the captured word.
- R3: While status bit 0 is set, further strobes leave the captured word unchanged.
- R4: A write of any data to address 3 clears status bit 0 and every pending interrupt on the next edge. After it, the request output stays low even when interrupts are enabled.
- R5: A read at address 2 returns the status word. Bit 0 is the strobe flag, bits 6:4 are the source-select bits of inputs 2:0, and all other bits read 0.
- R6: A write at address 5 loads source-select bits 3:0 from data bits 3:0. Select bits 7:4 stay 0, so inputs 4 to 7 always use edge triggering. A read at address 5 returns the eight select bits in bits 7:0.
- R7: A write at address 4 replaces all eight enable bits with data bits 7:0. A read at address 4 returns them in bits 7:0.
- R8: With its select bit 0, a rising edge on synchronised input n (n < 8) sets interrupt n pending on the following edge, three edges after the pin rises. Pending stays set after the input falls.
- R9: With its select bit 1, input n becomes pending only when an accepted strobe captures a 1 on it. Input edges on their own, and strobes ignored because the flag is set, do not make it pending.
- R10: The request output is high exactly while some enabled interrupt is pending. The vector output is the base input plus the lowest enabled pending index, and it is 0 while the request is low.
- R11: After reset the status word, the captured word, the enables, the select bits and the request output are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins | input | 24 | Asynchronous input lines |
| strobe | input | 1 | Asynchronous capture strobe |
| wr_en | input | 1 | Register write strobe for `addr` |
| addr | input | 3 | Register address for both read and write |
| wr_data | input | 24 | Write data |
| rd_data | output | 24 | Combinational read data for `addr` |
| vec_base | input | 8 | Base of the interrupt vector |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Vector of the highest-priority request |

## Verification
The two synchroniser flops make a pin change visible on the live read after two edges. The strobe edge detector adds one more edge, so the flag and snapshot are due three edges after the strobe pin rises. An edge-triggered interrupt is due three edges after its pin rises. A register write or a clear takes effect on the edge that samples it. The bench drives and samples on falling edges and counts rising edges explicitly. It checks one edge early, where the old value must still show, and then again on the due edge, so a missing or extra register stage shows up as a failure.

// File: rtl/sci_pkg.sv
// Shared definitions for the strobed input capture port.
// Assumes a 3-bit register address; codes below are the register map.
package sci_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_LIVE   = 3'd0,
        A_SNAP   = 3'd1,
        A_STATUS = 3'd2,
        A_CLEAR  = 3'd3,
        A_ENABLE = 3'd4,
        A_SOURCE = 3'd5
    } sci_addr_e;
endpackage

// File: rtl/sci_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous lines.
// Assumes each line is a level that is stable for several clocks;
// no cross-line coherence is promised.
module sci_sync #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two stages in series, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sci_capture.sv
// Strobe edge detector, snapshot register and sticky valid flag.
// Assumes stb and din are already synchronised. A clear in the same
// cycle as a strobe edge wins, and that strobe is dropped.
module sci_capture #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    input  logic         stb,
    input  logic         clr,
    output logic [W-1:0] cap,
    output logic         flag,
    output logic         take
);
    logic stb_prev;

    // Accept a strobe rising edge only while no valid snapshot is held.
    assign take = stb & ~stb_prev & ~flag & ~clr;

    // Track the strobe level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= 1'b0;
        else        stb_prev <= stb;
    end

    // Load the snapshot and set the flag on an accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap  <= '0;
            flag <= 1'b0;
        end else if (clr) begin
            flag <= 1'b0;
        end else if (take) begin
            cap  <= din;
            flag <= 1'b1;
        end
    end

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr |=> $stable(cap)); // R3
    AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !flag); // R4
endmodule

// File: rtl/sci_irq.sv
// Per-input interrupt pending bits, masking and vector selection.
// Assumes din and take come from synchronised logic. Lower index has
// higher priority. The vector adds the index to base modulo 2**VW.
module sci_irq #(
    parameter int N  = 8,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  din,
    input  logic [N-1:0]  src,
    input  logic [N-1:0]  en,
    input  logic          take,
    input  logic          clr,
    input  logic [VW-1:0] base,
    output logic          irq,
    output logic [VW-1:0] vec
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     din_prev;
    logic [N-1:0]     pend;
    logic [N-1:0]     set_now;
    logic [N-1:0]     active;
    logic [IDX_W-1:0] idx;

    // Remember input levels to find rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) din_prev <= '0;
        else        din_prev <= din;
    end

    // Edge-sourced inputs fire on a rise; strobe-sourced ones on a captured 1.
    assign set_now = (din & ~din_prev & ~src) | ({N{take}} & din & src);

    // Sticky pending bits, dropped only by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   pend <= '0;
        else if (clr) pend <= '0;
        else          pend <= pend | set_now;
    end

    assign active = pend & en;
    assign irq    = |active;

    // Lowest enabled pending index wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (active[i]) idx = IDX_W'(i);
        end
    end

    assign vec = irq ? (base + VW'(idx)) : '0;

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((pend & $past(pend)) == $past(pend))); // R8
    AST_CLEAR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !irq); // R4
    AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((vec - base) < VW'(N))); // R10
endmodule

// File: rtl/strobe_capture_irq.sv
// Top level: synchronisers, snapshot unit, interrupt unit and registers.
// Assumes single-cycle write strobes and a combinational read path.
// Only the low SRC_W source-select bits are writable; the rest stay 0.
module strobe_capture_irq #(
    parameter int WIDTH = 24,
    parameter int NIRQ  = 8,
    parameter int SRC_W = 4,
    parameter int VW    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          pins,
    input  logic                      strobe,
    input  logic                      wr_en,
    input  logic [sci_pkg::ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]          wr_data,
    output logic [WIDTH-1:0]          rd_data,
    input  logic [VW-1:0]             vec_base,
    output logic                      irq,
    output logic [VW-1:0]             irq_vec
);
    import sci_pkg::*;

    localparam int          STAT_SRC_LSB = 4;
    localparam int          STAT_SRC_W   = 3;
    localparam logic [NIRQ-1:0] SRC_MASK = NIRQ'((1 << SRC_W) - 1);

    logic [WIDTH:0]     sync_q;
    logic [WIDTH-1:0]   live;
    logic               stb_s;
    logic [WIDTH-1:0]   snap;
    logic               flag;
    logic               take;
    logic               clr;
    logic [NIRQ-1:0]    en_q;
    logic [NIRQ-1:0]    src_q;
    logic [WIDTH-1:0]   status;

    sci_sync #(.W(WIDTH + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({strobe, pins}),
        .q     (sync_q)
    );

    assign live  = sync_q[WIDTH-1:0];
    assign stb_s = sync_q[WIDTH];
    assign clr   = wr_en && (addr == A_CLEAR);

    sci_capture #(.W(WIDTH)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (live),
        .stb   (stb_s),
        .clr   (clr),
        .cap   (snap),
        .flag  (flag),
        .take  (take)
    );

    sci_irq #(.N(NIRQ), .VW(VW)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (live[NIRQ-1:0]),
        .src   (src_q),
        .en    (en_q),
        .take  (take),
        .clr   (clr),
        .base  (vec_base),
        .irq   (irq),
        .vec   (irq_vec)
    );

    // Enable and source-select registers, written by address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            src_q <= '0;
        end else if (wr_en) begin
            if (addr == A_ENABLE) en_q  <= wr_data[NIRQ-1:0];
            if (addr == A_SOURCE) src_q <= wr_data[NIRQ-1:0] & SRC_MASK;
        end
    end

    // Assemble the status word: flag at bit 0, low select bits above.
    always_comb begin
        status = '0;
        status[0] = flag;
        status[STAT_SRC_LSB +: STAT_SRC_W] = src_q[STAT_SRC_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_LIVE:   rd_data = live;
            A_SNAP:   rd_data = snap;
            A_STATUS: rd_data = status;
            A_ENABLE: rd_data = WIDTH'(en_q);
            A_SOURCE: rd_data = WIDTH'(src_q);
            default:  rd_data = '0;
        endcase
    end

    AST_SRC_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q & ~SRC_MASK) == '0); // R6
    AST_WRITE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (addr == A_ENABLE) |=> (en_q == $past(wr_data[NIRQ-1:0]))); // R7
endmodule

// File: tb/strobe_capture_irq_tb.sv
module strobe_capture_irq_tb;
    localparam int CLK_P = 10;
    localparam logic [7:0] BASE = 8'h7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] pins = '0;
    logic        strobe = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [23:0] wr_data = '0;
    logic [23:0] rd_data;
    logic [7:0]  vec_base = BASE;
    logic        irq;
    logic [7:0]  irq_vec;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    strobe_capture_irq u_dut (
        .clk(clk), .rst_n(rst_n), .pins(pins), .strobe(strobe),
        .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .vec_base(vec_base), .irq(irq), .irq_vec(irq_vec)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [23:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [23:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    // Strobe high for three edges (flag due on the third), then low.
    task automatic pulse_strobe();
        strobe = 1'b1;
        tick(3);
        strobe = 1'b0;
        tick(3);
    endtask

    task automatic t_reset();
        logic [23:0] d;
        rd(3'd2, d); chk("R11 status", d, 0);
        rd(3'd1, d); chk("R11 snapshot", d, 0);
        rd(3'd4, d); chk("R11 enable", d, 0);
        rd(3'd5, d); chk("R11 source", d, 0);
        chk("R11 irq", irq, 0);
    endtask

    task automatic t_live();
        logic [23:0] d;
        pins = 24'hA5C3F0;
        tick(1);
        rd(3'd0, d); chk("R1 one edge", d, 24'h0);
        tick(1);
        rd(3'd0, d); chk("R1 two edges", d, 24'hA5C3F0);
    endtask

    task automatic t_strobe();
        logic [23:0] d;
        pins = 24'h123456;
        tick(3);
        strobe = 1'b1;
        tick(2);
        rd(3'd2, d); chk("R2 flag early", d[0], 0);
        tick(1);
        rd(3'd2, d); chk("R2 flag due", d[0], 1);
        rd(3'd1, d); chk("R2 snapshot", d, 24'h123456);
        strobe = 1'b0;
        tick(3);
    endtask

    task automatic t_hold();
        logic [23:0] d;
        pins = 24'h654321;
        tick(3);
        pulse_strobe();
        rd(3'd1, d); chk("R3 frozen", d, 24'h123456);
    endtask

    task automatic t_clear();
        logic [23:0] d;
        wr(3'd3, 24'h0);
        rd(3'd2, d); chk("R4 flag cleared", d[0], 0);
        pulse_strobe();
        rd(3'd1, d); chk("R2 recapture", d, 24'h654321);
        wr(3'd3, 24'hFFFFFF);
    endtask

    task automatic t_source();
        logic [23:0] d;
        wr(3'd5, 24'h0000FF);
        rd(3'd5, d); chk("R6 only low bits", d, 24'h00000F);
        rd(3'd2, d); chk("R5 status all", d, 24'h000070);
        wr(3'd5, 24'h000005);
        rd(3'd2, d); chk("R5 status 101", d, 24'h000050);
        wr(3'd5, 24'h0);
    endtask

    task automatic t_enable();
        logic [23:0] d;
        wr(3'd4, 24'h0000A5);
        rd(3'd4, d); chk("R7 enable A5", d, 24'h0000A5);
        wr(3'd4, 24'hFFFF3C);
        rd(3'd4, d); chk("R7 enable replaced", d, 24'h00003C);
    endtask

    task automatic t_edge_irq();
        pins = '0;
        tick(4);
        wr(3'd3, 0);
        wr(3'd4, 24'hFF);
        chk("R4 no irq after clear", irq, 0);
        pins[2] = 1'b1;
        tick(2);
        chk("R8 irq early", irq, 0);
        tick(1);
        chk("R8 irq due", irq, 1);
        chk("R10 vector 2", irq_vec, BASE + 8'd2);
        pins[2] = 1'b0;
        tick(4);
        chk("R8 sticky", irq, 1);
        pins[5] = 1'b1;
        tick(4);
        chk("R10 lowest wins", irq_vec, BASE + 8'd2);
        wr(3'd4, 24'hFB);
        chk("R10 masked picks 5", irq_vec, BASE + 8'd5);
        wr(3'd4, 24'h00);
        chk("R10 irq off when masked", irq, 0);
        chk("R10 vector zero", irq_vec, 0);
        wr(3'd3, 0);
        wr(3'd4, 24'hFF);
        chk("R4 pending dropped", irq, 0);
        pins[5] = 1'b0;
        tick(4);
    endtask

    task automatic t_strobe_irq();
        wr(3'd5, 24'h02);
        pulse_strobe();
        pins[1] = 1'b1;
        tick(4);
        chk("R9 edge ignored", irq, 0);
        pulse_strobe();
        chk("R9 held-flag strobe ignored", irq, 0);
        wr(3'd3, 0);
        strobe = 1'b1;
        tick(2);
        chk("R9 irq early", irq, 0);
        tick(1);
        chk("R9 irq on capture", irq, 1);
        chk("R9 vector 1", irq_vec, BASE + 8'd1);
        strobe = 1'b0;
        tick(3);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_live();
        t_strobe();
        t_hold();
        t_clear();
        t_source();
        t_enable();
        t_edge_irq();
        t_strobe_irq();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule